// File: doc/BRIEF.md
# DMA Address and Count Engine with Ring Regions

This block drives the addresses and the unit counter of a single DMA channel. Software loads a source start, a destination start and a number of units. The channel then waits for transfer requests. Each accepted request moves a programmed number of units. For each unit, the engine first issues the read accesses at the source and then the write accesses at the destination. A unit whose address is not naturally aligned is broken into smaller aligned accesses. After the last write access of a unit, both addresses step by their own rule and the counter drops by one.

Each side has its own step rule: hold, up, down, or add a signed offset. Each side may also be confined to a power-of-two ring, in which only the low bits move and the high bits keep the value they were loaded with. Two sticky request flags tell the processor why the channel stopped. One means all units are done. The other is an early stop, caused either by a request that asks for more units than remain or by a ring wrap while stop-on-wrap is enabled.

Top module: `dma_addr_gen`

## Requirements
- R1: The step mode is encoded as 00 = hold, 01 = increase, 10 = decrease. Unit size is encoded as 00 = byte, 01 = word, 10 = longword. In increase or decrease mode, an address moves by the unit size in bytes (1, 2 or 4) after each unit, and a held address never moves.
- R2: In mode 11, an address advances by its own 32-bit offset, taken modulo 2^32, after each unit. This allows strides larger than the unit and negative strides.
- R3: A nonzero ring field n (values above 27 act as 27) keeps the address bits from n upward at their loaded value, so the low n bits wrap modulo 2^n. A ring field of 0 disables the ring. Source and destination have independent ring fields.
- R4: Each access is naturally aligned. A longword at offset 0 is one longword access. A longword at offset 2 is word, word. A longword at offset 1 or 3 is byte, word, byte. A word at an odd address is byte, byte. Bus size uses the same encoding as unit size.
- R5: Within a unit, all source reads (bus_write = 0) come before all destination writes (bus_write = 1), each piece at base + bytes already moved. Addresses and the counter change only when the last write piece is taken (bus_valid and bus_ready).
- R6: In the waiting state, a request is accepted when units_left is at least the burst (burst 0 counts as 1). Acceptance raises xfer_ack for exactly one cycle, and the channel then moves burst units before it waits again.
- R7: When the counter reaches zero, irq_end is set and the channel goes idle (busy = 0, no bus_valid).
- R8: A request that arrives while units_left is below the burst gets no acknowledge and causes no bus access. It sets irq_esc, and the channel goes idle with the counter unchanged.
- R9: When a unit update wraps a ring and cfg_wrap_stop is 1, irq_esc is set and the channel goes idle after that unit, with the wrapped address kept. With cfg_wrap_stop at 0, the wrap is silent and the transfer continues.
- R10: The flags stay set until their irq_clr bit (bit 0 = end, bit 1 = escape) is pulsed. A set event wins over a clear in the same cycle.
- R11: After reset, busy, bus_valid, xfer_ack, irq_end and irq_esc are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe: load starts and unit count, enter waiting state |
| cfg_src_start | input | AW | Source start address |
| cfg_dst_start | input | AW | Destination start address |
| cfg_units | input | CW | Number of units to move |
| cfg_unit_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source step mode |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_src_offset | input | AW | Source stride for mode 11 |
| cfg_dst_offset | input | AW | Destination stride for mode 11 |
| cfg_src_ring | input | 5 | Source ring width in bits, 0 = off |
| cfg_dst_ring | input | 5 | Destination ring width in bits, 0 = off |
| cfg_wrap_stop | input | 1 | Stop with escape flag on ring wrap |
| cfg_burst | input | BW | Units moved per accepted request |
| xfer_req | input | 1 | Transfer request |
| xfer_ack | output | 1 | One-cycle acceptance pulse |
| bus_valid | output | 1 | An access is presented |
| bus_write | output | 1 | 0 = source read, 1 = destination write |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_ready | input | 1 | Access taken this cycle |
| src_addr | output | AW | Current source unit address |
| dst_addr | output | AW | Current destination unit address |
| units_left | output | CW | Units still to move |
| busy | output | 1 | Channel not idle |
| irq_end | output | 1 | Sticky end flag |
| irq_esc | output | 1 | Sticky early-stop flag |
| irq_clr | input | 2 | Write-one-to-clear strobes for the flags |

## Verification
The bench targets misaligned longwords at every byte offset and odd words, with the ready signal stalling at random. A design that split by the wrong address bits, or stepped its addresses mid-unit, would put a piece at a shifted address or with the wrong size. Ring cases cross the region edge going up and going down. Confining the wrong bits would leave the ring, and a missing stop-on-wrap would produce accesses the scoreboard does not expect. A short final request and a negative offset stride check that the design neither acknowledges too much nor makes a sign error in the address arithmetic.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_UP   = 2'b01,
    AM_DOWN = 2'b10,
    AM_OFS  = 2'b11
  } step_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } unit_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_READ  = 2'b10,
    ST_WRITE = 2'b11
  } eng_state_e;

  localparam int RING_MAX_BITS = 27;

  // bytes in one unit of the given size code
  function automatic logic [2:0] f_unit_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // largest aligned access that fits at this address with rem bytes left
  function automatic logic [1:0] f_piece_size(input logic [1:0] lo, input logic [2:0] rem);
    if (rem >= 3'd4 && lo == 2'b00) return SZ_LONG;
    else if (rem >= 3'd2 && !lo[0]) return SZ_WORD;
    else return SZ_BYTE;
  endfunction

endpackage

// File: rtl/dmaag_addr_unit.sv
module dmaag_addr_unit
  import dmaag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  load_addr,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  offset,
  input  logic [RBW-1:0] ring_bits,
  input  logic [1:0]     size,
  input  logic [2:0]     idx,
  input  logic           upd,
  output logic [AW-1:0]  addr,
  output logic [AW-1:0]  piece_addr,
  output logic [1:0]     piece_size,
  output logic [2:0]     piece_bytes,
  output logic           wrap_evt
);

  // ones on the bits that are free to move
  function automatic logic [AW-1:0] f_region_mask(input logic [RBW-1:0] nb);
    int n;
    logic [AW-1:0] m;
    n = int'(nb);
    if (n > RING_MAX_BITS) n = RING_MAX_BITS;
    if (n > AW - 1) n = AW - 1;
    m = '0;
    for (int i = 0; i < AW; i++) m[i] = (nb == '0) || (i < n);
    return m;
  endfunction

  function automatic logic [AW-1:0] f_confine(input logic [AW-1:0] base,
                                              input logic [AW-1:0] raw,
                                              input logic [AW-1:0] m);
    return (base & ~m) | (raw & m);
  endfunction

  function automatic logic [AW-1:0] f_step_raw(input logic [AW-1:0] base,
                                               input logic [1:0] md,
                                               input logic [2:0] ub,
                                               input logic [AW-1:0] ofs);
    case (md)
      AM_HOLD: return base;
      AM_UP:   return base + AW'(ub);
      AM_DOWN: return base - AW'(ub);
      default: return base + ofs;
    endcase
  endfunction

  logic [AW-1:0] region_mask;
  logic          ring_on;
  logic [2:0]    unit_bytes;
  logic [AW-1:0] raw_next;
  logic [AW-1:0] next_addr;

  assign region_mask = f_region_mask(ring_bits);
  assign ring_on     = (ring_bits != '0);
  assign unit_bytes  = f_unit_bytes(size);
  assign raw_next    = f_step_raw(addr, mode, unit_bytes, offset);
  assign next_addr   = f_confine(addr, raw_next, region_mask);
  assign wrap_evt    = upd && ring_on && ((raw_next & ~region_mask) != (addr & ~region_mask));

  assign piece_addr  = f_confine(addr, addr + AW'(idx), region_mask);
  assign piece_size  = f_piece_size(piece_addr[1:0], unit_bytes - idx);
  assign piece_bytes = 3'd1 << piece_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (upd)  addr <= next_addr;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !load) |=> $stable(addr)) else $error("address moved mid-unit"); // R5

  AST_RING_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ring_on && !load) |=> ((addr & ~$past(region_mask)) == ($past(addr) & ~$past(region_mask))))
    else $error("ring upper bits changed"); // R3

endmodule

// File: rtl/dmaag_ctrl.sv
module dmaag_ctrl
  import dmaag_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_count,
  input  logic [BW-1:0] burst,
  input  logic          req,
  input  logic          bus_ready,
  input  logic [1:0]    size,
  input  logic [2:0]    piece_bytes,
  input  logic          wrap_hit,
  output eng_state_e    state,
  output logic [2:0]    idx,
  output logic          ack,
  output logic          upd,
  output logic          end_evt,
  output logic          esc_evt,
  output logic [CW-1:0] count
);

  logic [CW-1:0] burst_eff;
  logic [CW-1:0] blk_left;
  logic          short_req;
  logic          last_piece;
  logic [3:0]    idx_sum;

  assign burst_eff  = (burst == '0) ? CW'(1) : CW'(burst);
  assign short_req  = (count < burst_eff);
  assign ack        = (state == ST_WAIT) && req && !short_req;
  assign idx_sum    = {1'b0, idx} + {1'b0, piece_bytes};
  assign last_piece = (idx_sum == {1'b0, f_unit_bytes(size)});
  assign upd        = (state == ST_WRITE) && bus_ready && last_piece;
  assign end_evt    = (load && load_count == '0) || (upd && count == CW'(1));
  assign esc_evt    = ((state == ST_WAIT) && req && short_req)
                    || (upd && count != CW'(1) && wrap_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      count    <= '0;
      blk_left <= '0;
    end else if (load) begin
      count    <= load_count;
      idx      <= '0;
      blk_left <= '0;
      state    <= (load_count == '0) ? ST_IDLE : ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: begin
          if (ack) begin
            blk_left <= burst_eff;
            state    <= ST_READ;
          end else if (req) begin
            state <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (bus_ready) begin
            if (last_piece) begin
              idx   <= '0;
              state <= ST_WRITE;
            end else begin
              idx <= idx_sum[2:0];
            end
          end
        end
        ST_WRITE: begin
          if (bus_ready) begin
            if (last_piece) begin
              idx      <= '0;
              count    <= count - CW'(1);
              blk_left <= blk_left - CW'(1);
              if (count == CW'(1) || wrap_hit) state <= ST_IDLE;
              else if (blk_left == CW'(1))     state <= ST_WAIT;
              else                             state <= ST_READ;
            end else begin
              idx <= idx_sum[2:0];
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !load) |=> !ack) else $error("ack longer than one cycle"); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load) |=> (count == $past(count) - CW'(1))) else $error("count step wrong"); // R5

  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (count != '0)) else $error("active with zero count"); // R7

endmodule

// File: rtl/dmaag_irq.sv
module dmaag_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       end_evt,
  input  logic       esc_evt,
  input  logic [1:0] clr,
  output logic       irq_end,
  output logic       irq_esc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_end <= 1'b0;
      irq_esc <= 1'b0;
    end else begin
      irq_end <= end_evt | (irq_end & ~clr[0]);
      irq_esc <= esc_evt | (irq_esc & ~clr[1]);
    end
  end

  AST_END_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> irq_end) else $error("end flag missing"); // R7

  AST_ESC_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    esc_evt |=> irq_esc) else $error("escape flag missing"); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_end && !clr[0]) |=> irq_end) else $error("end flag dropped"); // R10

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dmaag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int BW  = 4,
  parameter int RBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_src_start,
  input  logic [AW-1:0]  cfg_dst_start,
  input  logic [CW-1:0]  cfg_units,
  input  logic [1:0]     cfg_unit_size,
  input  logic [1:0]     cfg_src_mode,
  input  logic [1:0]     cfg_dst_mode,
  input  logic [AW-1:0]  cfg_src_offset,
  input  logic [AW-1:0]  cfg_dst_offset,
  input  logic [RBW-1:0] cfg_src_ring,
  input  logic [RBW-1:0] cfg_dst_ring,
  input  logic           cfg_wrap_stop,
  input  logic [BW-1:0]  cfg_burst,
  input  logic           xfer_req,
  output logic           xfer_ack,
  output logic           bus_valid,
  output logic           bus_write,
  output logic [AW-1:0]  bus_addr,
  output logic [1:0]     bus_size,
  input  logic           bus_ready,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic [CW-1:0]  units_left,
  output logic           busy,
  output logic           irq_end,
  output logic           irq_esc,
  input  logic [1:0]     irq_clr
);

  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  eng_state_e               state;
  logic [2:0]               idx;
  logic                     upd;
  logic                     end_evt;
  logic                     esc_evt;
  logic                     wrap_hit;
  logic [2:0]               act_bytes;

  logic [NSIDE-1:0][AW-1:0]  s_start, s_offset, s_addr, s_piece_addr;
  logic [NSIDE-1:0][1:0]     s_mode, s_piece_size;
  logic [NSIDE-1:0][RBW-1:0] s_ring;
  logic [NSIDE-1:0][2:0]     s_piece_bytes;
  logic [NSIDE-1:0]          s_wrap;

  assign s_start  = {cfg_dst_start, cfg_src_start};
  assign s_offset = {cfg_dst_offset, cfg_src_offset};
  assign s_mode   = {cfg_dst_mode, cfg_src_mode};
  assign s_ring   = {cfg_dst_ring, cfg_src_ring};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dmaag_addr_unit #(.AW(AW), .RBW(RBW)) i_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (cfg_load),
      .load_addr   (s_start[g]),
      .mode        (s_mode[g]),
      .offset      (s_offset[g]),
      .ring_bits   (s_ring[g]),
      .size        (cfg_unit_size),
      .idx         ((state == ST_WRITE) == (g == 1) ? idx : 3'd0),
      .upd         (upd),
      .addr        (s_addr[g]),
      .piece_addr  (s_piece_addr[g]),
      .piece_size  (s_piece_size[g]),
      .piece_bytes (s_piece_bytes[g]),
      .wrap_evt    (s_wrap[g])
    );
  end

  assign bus_write = (state == ST_WRITE);
  assign act_bytes = s_piece_bytes[bus_write];
  assign wrap_hit  = cfg_wrap_stop && (|s_wrap);

  dmaag_ctrl #(.CW(CW), .BW(BW)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cfg_load),
    .load_count  (cfg_units),
    .burst       (cfg_burst),
    .req         (xfer_req),
    .bus_ready   (bus_ready),
    .size        (cfg_unit_size),
    .piece_bytes (act_bytes),
    .wrap_hit    (wrap_hit),
    .state       (state),
    .idx         (idx),
    .ack         (xfer_ack),
    .upd         (upd),
    .end_evt     (end_evt),
    .esc_evt     (esc_evt),
    .count       (units_left)
  );

  dmaag_irq i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .end_evt (end_evt),
    .esc_evt (esc_evt),
    .clr     (irq_clr),
    .irq_end (irq_end),
    .irq_esc (irq_esc)
  );

  assign bus_valid = (state == ST_READ) || (state == ST_WRITE);
  assign bus_addr  = s_piece_addr[bus_write];
  assign bus_size  = s_piece_size[bus_write];
  assign src_addr  = s_addr[0];
  assign dst_addr  = s_addr[1];
  assign busy      = (state != ST_IDLE);

  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_size != SZ_LONG || bus_addr[1:0] == 2'b00)
                && (bus_size != SZ_WORD || !bus_addr[0]))) else $error("misaligned access"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_valid && !xfer_ack)) else $error("activity while idle"); // R11

endmodule

// File: tb/test_dma_addr_gen.sv
`timescale 1ns/1ps
module test_dma_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_src_start = '0, cfg_dst_start = '0;
  logic [15:0] cfg_units = '0;
  logic [1:0]  cfg_unit_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic [31:0] cfg_src_offset = '0, cfg_dst_offset = '0;
  logic [4:0]  cfg_src_ring = '0, cfg_dst_ring = '0;
  logic        cfg_wrap_stop = 1'b0;
  logic [3:0]  cfg_burst = '0;
  logic        xfer_req = 1'b0;
  logic        xfer_ack, bus_valid, bus_write, busy, irq_end, irq_esc;
  logic [31:0] bus_addr, src_addr, dst_addr;
  logic [1:0]  bus_size;
  logic        bus_ready = 1'b1;
  logic [15:0] units_left;
  logic [1:0]  irq_clr = '0;

  int checks = 0;
  int errors = 0;
  bit stall = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [34:0] exp_q[$];
  longint m_src, m_dst;

  always #2.5 clk = ~clk;

  dma_addr_gen i_dma_addr_gen (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ring model: keep bits above n of base, take low n bits of raw
  function automatic longint ring(input longint base, input longint raw, input int bits);
    longint r;
    if (bits == 0) return raw & 64'hFFFF_FFFF;
    r = longint'(1) << bits;
    return ((base & ~(r - 1)) | (raw & (r - 1))) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint nxt(input longint a, input int mode, input int sz,
                                 input longint ofs, input int bits);
    longint ub, raw;
    ub = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    case (mode)
      0: raw = a;
      1: raw = a + ub;
      2: raw = a - ub;
      default: raw = a + ofs;
    endcase
    return ring(a, raw, bits);
  endfunction

  // R4 split table
  task automatic push_side(input bit wr, input longint base, input int bits, input int sz);
    int plan[3];
    int np;
    longint pos, a;
    np = 1; plan[0] = sz;
    if (sz == 1 && base % 2 != 0) begin np = 2; plan[0] = 0; plan[1] = 0; end
    if (sz == 2) begin
      if (base % 4 == 2) begin np = 2; plan[0] = 1; plan[1] = 1; end
      else if (base % 2 == 1) begin np = 3; plan[0] = 0; plan[1] = 1; plan[2] = 0; end
    end
    pos = 0;
    for (int k = 0; k < np; k++) begin
      a = ring(base, base + pos, bits);
      exp_q.push_back({wr, a[31:0], plan[k][1:0]});
      pos += longint'(1) << plan[k];
    end
  endtask

  task automatic push_unit();
    int sz;
    sz = int'(cfg_unit_size);
    push_side(1'b0, m_src, int'(cfg_src_ring), sz);
    push_side(1'b1, m_dst, int'(cfg_dst_ring), sz);
    m_src = nxt(m_src, int'(cfg_src_mode), sz, longint'(cfg_src_offset), int'(cfg_src_ring));
    m_dst = nxt(m_dst, int'(cfg_dst_mode), sz, longint'(cfg_dst_offset), int'(cfg_dst_ring));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected access", longint'({bus_write, bus_addr, bus_size}), 0);
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        check({bus_write, bus_addr, bus_size} == e, "R4/R5 access {wr,addr,size}",
              longint'({bus_write, bus_addr, bus_size}), longint'(e));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_ready = stall ? lfsr[0] : 1'b1;
    end
  end

  task automatic start(input longint s, input longint d, input int units, input int burst);
    @(negedge clk);
    cfg_src_start = s[31:0]; cfg_dst_start = d[31:0];
    cfg_units = units[15:0]; cfg_burst = burst[3:0];
    cfg_load = 1'b1;
    m_src = s; m_dst = d;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "R5 accesses missing", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic request(input bit exp_ack, input int units, input string tag);
    @(negedge clk);
    xfer_req = 1'b1;
    #1;
    check(xfer_ack == exp_ack, tag, xfer_ack, exp_ack);
    for (int u = 0; u < units; u++) push_unit();
    @(negedge clk);
    xfer_req = 1'b0;
    check(xfer_ack == 1'b0, "R6 ack one cycle", xfer_ack, 0);
    drain();
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 2'b00;
    check(irq_end == 0 && irq_esc == 0, "R10 flags cleared", {irq_end, irq_esc}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && bus_valid == 0 && xfer_ack == 0 && irq_end == 0 && irq_esc == 0,
          "R11 reset state", {busy, bus_valid, xfer_ack, irq_end, irq_esc}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 up on both sides, words, two requests of two units
    cfg_unit_size = 2'b01; cfg_src_mode = 2'b01; cfg_dst_mode = 2'b01;
    start(32'h100, 32'h2000, 4, 2);
    request(1, 2, "R6 ack first request");
    check(busy == 1 && units_left == 2, "R6 waits after burst", units_left, 2);
    request(1, 2, "R6 ack second request");
    check(irq_end == 1 && busy == 0 && irq_esc == 0, "R7 end flag and idle", {irq_end, busy}, 2'b10);
    check(src_addr == 32'h108 && dst_addr == 32'h2008, "R1 up by word", src_addr, 32'h108);
    repeat (5) @(negedge clk);
    check(irq_end == 1, "R10 end flag sticky", irq_end, 1);
    clear_flags();

    // R1 down longword source, hold destination
    cfg_unit_size = 2'b10; cfg_src_mode = 2'b10; cfg_dst_mode = 2'b00;
    start(32'h400, 32'h3000, 2, 1);
    request(1, 1, "R1 request 1");
    request(1, 1, "R1 request 2");
    check(src_addr == 32'h3F8 && dst_addr == 32'h3000, "R1 down and hold", src_addr, 32'h3F8);
    clear_flags();

    // R2 offset strides, positive and negative
    cfg_src_mode = 2'b11; cfg_dst_mode = 2'b11;
    cfg_src_offset = 32'h40; cfg_dst_offset = 32'hFFFF_FFF8;
    start(32'h800, 32'h5000, 3, 3);
    request(1, 3, "R2 offset request");
    check(src_addr == 32'h8C0 && dst_addr == 32'h4FE8, "R2 offset stride", dst_addr, 32'h4FE8);
    clear_flags();

    // R4 misaligned longwords with stalls
    stall = 1;
    cfg_src_mode = 2'b01; cfg_dst_mode = 2'b01;
    start(32'h101, 32'h202, 3, 3);
    request(1, 3, "R4 misaligned longwords");
    check(src_addr == 32'h10D, "R4 longword step after split", src_addr, 32'h10D);
    clear_flags();
    cfg_unit_size = 2'b01; cfg_src_mode = 2'b10;
    start(32'h301, 32'h401, 2, 1);
    request(1, 1, "R4 odd word 1");
    request(1, 1, "R4 odd word 2");
    stall = 0;
    clear_flags();

    // R3 source ring of 8 bytes, no stop on wrap
    cfg_src_mode = 2'b01; cfg_dst_mode = 2'b01; cfg_src_ring = 5'd3; cfg_wrap_stop = 1'b0;
    start(32'h1004, 32'h6000, 4, 4);
    request(1, 4, "R3 ring request");
    check(src_addr == 32'h1004 && irq_esc == 0 && irq_end == 1, "R3 ring wraps silently", src_addr, 32'h1004);
    clear_flags();

    // R9 destination ring of 16 bytes going down, stop on wrap
    cfg_src_ring = 5'd0; cfg_dst_ring = 5'd4; cfg_wrap_stop = 1'b1;
    cfg_unit_size = 2'b10; cfg_src_mode = 2'b00; cfg_dst_mode = 2'b10;
    start(32'h100, 32'h7008, 5, 5);
    request(1, 3, "R9 ring stop request");
    check(irq_esc == 1 && irq_end == 0 && busy == 0, "R9 escape on wrap", {irq_esc, irq_end, busy}, 3'b100);
    check(units_left == 2 && dst_addr == 32'h700C, "R9 wrapped state kept", dst_addr, 32'h700C);
    clear_flags();

    // R8 short final request
    cfg_dst_ring = 5'd0; cfg_wrap_stop = 1'b0; cfg_unit_size = 2'b00;
    cfg_src_mode = 2'b01; cfg_dst_mode = 2'b01;
    start(32'h10, 32'h20, 3, 2);
    request(1, 2, "R6 first of short run");
    request(0, 0, "R8 short request not acked");
    check(irq_esc == 1 && irq_end == 0 && busy == 0 && units_left == 1,
          "R8 escape on short", units_left, 1);
    clear_flags();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule